// File: doc/BRIEF.md
# NAND Flash Host Port

This block sits between a simple memory-mapped host request interface and the pins of a raw 8-bit NAND flash device. A one-byte mode register drives the flash chip enable, command latch, address latch and write-protect pins directly. A second field of the mode register is passed out as an error-correction engine select. Software sets the latch pins first and then moves bytes through the data offset. The same data access becomes a command, address or data cycle, depending on the latch pins at that time.

Each byte moved through the data offset produces exactly one write strobe or one read strobe. Setup, pulse and hold lengths are set by parameters and counted in clock cycles. A wide (16-bit) access moves two flash bytes, low byte first. A status register shows the synchronised ready/busy line. An interrupt block latches edges of that line in a pending register that software clears by writing ones, and gates the pending flags through a mask register onto one interrupt output.

Top module: `nfc_host_port`

## Requirements
- R1: After reset nf_ce_n=1, nf_cle=0, nf_ale=0, nf_wp_n=0, nf_we_n=1, nf_re_n=1, nf_dq_oe=0, irq=0, host_ack=0, and the mode register reads 0x00.
- R2: The mode register sits at offset 4. Its pins follow it from the cycle after the write is accepted: nf_ce_n is the inverse of bit 4, nf_cle is bit 0, nf_ale is bit 1, nf_wp_n is bit 7 and ecc_sel is bits 6:5. Bits 3:2 are stored and read back only. Value 0x95 gives command cycles, 0x96 address cycles, 0x94 data cycles and 0x00 standby.
- R3: A write to offset 0 sends host_wdata[7:0] and then, when host_wide=1, host_wdata[15:8]. Each byte takes TSU cycles with nf_dq_oe=1 and nf_we_n=1, then TPW cycles with nf_we_n=0, then TH cycles with nf_we_n=1. nf_dq_out holds the byte for the whole byte period.
- R4: A narrow read of offset 0 gives one nf_re_n low pulse of TPW cycles. It returns the byte sampled in the last pulse cycle in host_rdata[7:0], with host_rdata[15:8]=0.
- R5: A wide read of offset 0 gives two nf_re_n pulses. It returns the first flash byte in host_rdata[7:0] and the second in host_rdata[15:8].
- R6: nf_we_n and nf_re_n are never low together, and nf_dq_oe is 0 whenever nf_re_n is low.
- R7: The status register at offset 5 reads 0x80 while the ready/busy line, after a two-stage synchroniser, shows busy (nf_rb_n=0), and reads 0x00 otherwise.
- R8: The pending register at offset 6 sets bit 0 on each busy-to-ready edge and bit 1 on each ready-to-busy edge of the synchronised line. Bits 3:2 read 0. Writing a 1 clears the matching bit, so 0x0F clears all of them. A set in the same cycle as a clear wins.
- R9: irq = mask[7] AND any(pending[3:0] AND mask[3:0]), where the mask register sits at offset 7. 0x81 enables the ready interrupt and 0x00 masks everything.
- R10: Writes to offsets 1, 2, 3 and 5 change no state, and reads of offsets 1, 2 and 3 return 0.
- R11: host_ack is high for exactly one cycle. It comes in the cycle after the request for register offsets, and N*(TSU+TPW+TH) cycles after the request edge for a data access of N bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | One-cycle access request, issued only while no access is pending |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_wide | input | 1 | Data offset only: 1 = two bytes, 0 = one byte |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, valid with host_ack |
| host_ack | output | 1 | Access complete |
| irq | output | 1 | Interrupt request |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_wp_n | output | 1 | Write protect, active low |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_out | output | 8 | Flash data out |
| nf_dq_oe | output | 1 | Flash data output enable |
| nf_dq_in | input | 8 | Flash data in |
| nf_rb_n | input | 1 | Flash ready (1) / busy (0) |
| ecc_sel | output | 2 | Error-correction engine select from the mode register |

## Verification
A corrupted mode register shows up on the latch and enable pins in the very next cycle. The bench compares those pins with its model on every clock, so such a fault is caught at once. A strobe engine with the wrong count or byte index shows up as a wrong strobe width, a wrong byte order in the flash log, or an acknowledge that comes in the wrong cycle. Each of these is seen within one access. A wrong pending or mask state changes irq in the cycle after the ready/busy edge or register write that exposes it, and the bench compares irq every clock.

// File: rtl/nfc_pkg.sv
// Shared offsets, mode bit positions and state type for the NAND host port.
// Assumes byte offsets on a 3-bit host address.
package nfc_pkg;
    localparam logic [2:0] OFF_DATA = 3'd0;
    localparam logic [2:0] OFF_MODE = 3'd4;
    localparam logic [2:0] OFF_STAT = 3'd5;
    localparam logic [2:0] OFF_PEND = 3'd6;
    localparam logic [2:0] OFF_MASK = 3'd7;

    localparam int MB_CLE = 0;
    localparam int MB_ALE = 1;
    localparam int MB_CE  = 4;
    localparam int MB_WP  = 7;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_SETUP,
        SQ_PULSE,
        SQ_HOLD
    } seq_state_t;
endpackage

// File: rtl/nfc_regs.sv
// Mode, status, pending and mask registers with the interrupt gate.
// Assumes wr_en is issued only for accepted register writes.
module nfc_regs
    import nfc_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    input  logic       rb_n,
    output logic [7:0] mode,
    output logic [7:0] rbyte,
    output logic       irq
);
    localparam int NPEND = 4;

    logic [SYNC_N-1:0] sync_q;
    logic              rb_prev_q;
    logic [NPEND-1:0]  pend_q;
    logic [7:0]        mask_q;
    logic [7:0]        mode_q;
    logic              rb_s;
    logic [NPEND-1:0]  pend_set;
    logic [NPEND-1:0]  pend_clr;

    assign rb_s = sync_q[SYNC_N-1];

    // Synchronise the ready/busy line and keep its previous value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q    <= '1;
            rb_prev_q <= 1'b1;
        end else begin
            sync_q    <= {sync_q[SYNC_N-2:0], rb_n};
            rb_prev_q <= rb_s;
        end
    end

    // Edge events that raise pending flags, and write-one clears.
    always_comb begin
        pend_set    = '0;
        pend_set[0] = rb_s & ~rb_prev_q;
        pend_set[1] = ~rb_s & rb_prev_q;
        pend_clr    = (wr_en && addr == OFF_PEND) ? wdata[NPEND-1:0] : '0;
    end

    // Register writes; a set beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            mask_q <= '0;
            pend_q <= '0;
        end else begin
            if (wr_en && addr == OFF_MODE) mode_q <= wdata;
            if (wr_en && addr == OFF_MASK) mask_q <= wdata;
            pend_q <= (pend_q & ~pend_clr) | pend_set;
        end
    end

    // Read multiplexer for the register offsets.
    always_comb begin
        case (addr)
            OFF_MODE: rbyte = mode_q;
            OFF_STAT: rbyte = {~rb_s, 7'b0};
            OFF_PEND: rbyte = {{(8-NPEND){1'b0}}, pend_q};
            OFF_MASK: rbyte = mask_q;
            default:  rbyte = 8'h00;
        endcase
    end

    assign mode = mode_q;
    assign irq  = mask_q[7] & (|(pend_q & mask_q[NPEND-1:0]));
endmodule

// File: rtl/nfc_bus_seq.sv
// Byte strobe engine: one or two bytes, each as setup, pulse, hold counts.
// Assumes start only while busy is low; TSU, TPW, TH are at least 1.
module nfc_bus_seq
    import nfc_pkg::*;
#(
    parameter int TSU = 2,
    parameter int TPW = 3,
    parameter int TH  = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        rd,
    input  logic        wide,
    input  logic [15:0] wdata,
    input  logic [7:0]  dq_in,
    output logic        busy,
    output logic        done,
    output logic [15:0] rdata,
    output logic        we_n,
    output logic        re_n,
    output logic [7:0]  dq_out,
    output logic        dq_oe
);
    localparam int MAXT = (TSU > TPW) ? ((TSU > TH) ? TSU : TH) : ((TPW > TH) ? TPW : TH);
    localparam int CW   = $clog2(MAXT + 1);

    seq_state_t    st_q;
    logic [CW-1:0] cnt_q;
    logic          idx_q;
    logic          wide_q;
    logic          rd_q;
    logic          done_q;
    logic [15:0]   wbuf_q;
    logic [15:0]   rbuf_q;

    // Phase counter walking setup, pulse and hold for each byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SQ_IDLE;
            cnt_q  <= '0;
            idx_q  <= 1'b0;
            wide_q <= 1'b0;
            rd_q   <= 1'b0;
            done_q <= 1'b0;
            wbuf_q <= '0;
            rbuf_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                SQ_IDLE: if (start) begin
                    st_q   <= SQ_SETUP;
                    cnt_q  <= CW'(TSU - 1);
                    idx_q  <= 1'b0;
                    wide_q <= wide;
                    rd_q   <= rd;
                    wbuf_q <= wdata;
                    if (rd) rbuf_q <= '0;
                end
                SQ_SETUP: if (cnt_q == '0) begin
                    st_q  <= SQ_PULSE;
                    cnt_q <= CW'(TPW - 1);
                end else cnt_q <= cnt_q - 1'b1;
                SQ_PULSE: if (cnt_q == '0) begin
                    st_q  <= SQ_HOLD;
                    cnt_q <= CW'(TH - 1);
                    if (rd_q) begin
                        if (idx_q) rbuf_q[15:8] <= dq_in;
                        else       rbuf_q[7:0]  <= dq_in;
                    end
                end else cnt_q <= cnt_q - 1'b1;
                SQ_HOLD: if (cnt_q == '0) begin
                    if (wide_q && !idx_q) begin
                        idx_q <= 1'b1;
                        st_q  <= SQ_SETUP;
                        cnt_q <= CW'(TSU - 1);
                    end else begin
                        st_q   <= SQ_IDLE;
                        done_q <= 1'b1;
                    end
                end else cnt_q <= cnt_q - 1'b1;
                default: st_q <= SQ_IDLE;
            endcase
        end
    end

    // Pin decode from the phase state.
    always_comb begin
        we_n   = !(st_q == SQ_PULSE && !rd_q);
        re_n   = !(st_q == SQ_PULSE && rd_q);
        dq_oe  = (st_q != SQ_IDLE) && !rd_q;
        dq_out = idx_q ? wbuf_q[15:8] : wbuf_q[7:0];
        busy   = st_q != SQ_IDLE;
    end

    assign done  = done_q;
    assign rdata = rbuf_q;
endmodule

// File: rtl/nfc_host_port.sv
// Top of the NAND host port: routes host requests to the registers or the
// strobe engine and drives the flash control pins from the mode register.
// Assumes host_req is issued only when no earlier access awaits its ack.
module nfc_host_port
    import nfc_pkg::*;
#(
    parameter int TSU    = 2,
    parameter int TPW    = 3,
    parameter int TH     = 1,
    parameter int SYNC_N = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_req,
    input  logic        host_wr,
    input  logic        host_wide,
    input  logic [2:0]  host_addr,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic        host_ack,
    output logic        irq,
    output logic        nf_ce_n,
    output logic        nf_cle,
    output logic        nf_ale,
    output logic        nf_wp_n,
    output logic        nf_we_n,
    output logic        nf_re_n,
    output logic [7:0]  nf_dq_out,
    output logic        nf_dq_oe,
    input  logic [7:0]  nf_dq_in,
    input  logic        nf_rb_n,
    output logic [1:0]  ecc_sel
);
    logic        seq_busy;
    logic        seq_done;
    logic [15:0] seq_rdata;
    logic        accept;
    logic        is_data;
    logic        reg_wr;
    logic [7:0]  mode;
    logic [7:0]  rbyte;
    logic        reg_ack_q;
    logic [7:0]  reg_rdata_q;

    assign accept  = host_req && !seq_busy;
    assign is_data = host_addr == OFF_DATA;
    assign reg_wr  = accept && !is_data && host_wr;

    nfc_regs #(.SYNC_N(SYNC_N)) regs_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr),
        .addr  (host_addr),
        .wdata (host_wdata[7:0]),
        .rb_n  (nf_rb_n),
        .mode  (mode),
        .rbyte (rbyte),
        .irq   (irq)
    );

    nfc_bus_seq #(.TSU(TSU), .TPW(TPW), .TH(TH)) seq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (accept && is_data),
        .rd     (!host_wr),
        .wide   (host_wide),
        .wdata  (host_wdata),
        .dq_in  (nf_dq_in),
        .busy   (seq_busy),
        .done   (seq_done),
        .rdata  (seq_rdata),
        .we_n   (nf_we_n),
        .re_n   (nf_re_n),
        .dq_out (nf_dq_out),
        .dq_oe  (nf_dq_oe)
    );

    // Register accesses complete one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_ack_q   <= 1'b0;
            reg_rdata_q <= '0;
        end else begin
            reg_ack_q <= accept && !is_data;
            if (accept && !is_data) reg_rdata_q <= rbyte;
        end
    end

    // Acknowledge and read data from whichever path finished.
    always_comb begin
        host_ack   = reg_ack_q | seq_done;
        host_rdata = seq_done ? seq_rdata : {8'h00, reg_rdata_q};
    end

    // Flash control pins straight from the mode register.
    always_comb begin
        nf_ce_n = ~mode[MB_CE];
        nf_cle  = mode[MB_CLE];
        nf_ale  = mode[MB_ALE];
        nf_wp_n = mode[MB_WP];
        ecc_sel = mode[6:5];
    end
endmodule

// File: rtl/nfc_host_port_chk.sv
// Property checker for the NAND host port, bound to every instance of the top.
// Assumes the same single-outstanding-request host discipline as the top.
module nfc_host_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_req,
    input logic       host_wr,
    input logic [2:0] host_addr,
    input logic [7:0] host_wdata,
    input logic       host_ack,
    input logic       irq,
    input logic       nf_we_n,
    input logic       nf_re_n,
    input logic       nf_dq_oe,
    input logic [7:0] nf_dq_out
);
    // R6: the two strobes never overlap
    a_r6_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nf_we_n && !nf_re_n));

    // R6: no bus drive while the flash drives data
    a_r6_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !nf_re_n |-> !nf_dq_oe);

    // R3: the byte is held steady while the write strobe is low
    a_r3_data_stable_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !nf_we_n |=> (nf_we_n || $stable(nf_dq_out)));

    // R9: writing 0x00 to the mask quiets the interrupt
    a_r9_mask_all_quiets_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_wr && host_addr == 3'd7 && host_wdata == 8'h00) |=> !irq);

    // R11: acknowledge lasts a single cycle
    a_r11_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);
endmodule

bind nfc_host_port nfc_host_port_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_req   (host_req),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata[7:0]),
    .host_ack   (host_ack),
    .irq        (irq),
    .nf_we_n    (nf_we_n),
    .nf_re_n    (nf_re_n),
    .nf_dq_oe   (nf_dq_oe),
    .nf_dq_out  (nf_dq_out)
);

// File: tb/nfc_host_port_tb_top.sv
// Bench for the NAND host port: behavioural register model compared on every
// clock, a flash responder with a read queue and a write log, and directed tests.
module nfc_host_port_tb_top;
    localparam int B_TSU = 2;
    localparam int B_TPW = 3;
    localparam int B_TH  = 1;
    localparam int B_T   = B_TSU + B_TPW + B_TH;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_wide = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_ack;
    logic        irq;
    logic        nf_ce_n, nf_cle, nf_ale, nf_wp_n, nf_we_n, nf_re_n, nf_dq_oe;
    logic [7:0]  nf_dq_out;
    logic [7:0]  nf_dq_in = '0;
    logic        nf_rb_n = 1'b1;
    logic [1:0]  ecc_sel;

    int checks = 0;
    int fails = 0;
    bit live = 1'b0;

    always #5 clk = ~clk;

    nfc_host_port #(.TSU(B_TSU), .TPW(B_TPW), .TH(B_TH)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_wide(host_wide), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_ack(host_ack), .irq(irq),
        .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_wp_n(nf_wp_n),
        .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_dq_out(nf_dq_out),
        .nf_dq_oe(nf_dq_oe), .nf_dq_in(nf_dq_in), .nf_rb_n(nf_rb_n),
        .ecc_sel(ecc_sel)
    );

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural model of the registers and the synchronised ready line.
    logic [7:0] m_mode = 0, m_mask = 0;
    logic [3:0] m_pend = 0;
    logic       m_b1 = 1, m_b2 = 1, m_bp = 1;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode <= 0; m_mask <= 0; m_pend <= 0;
            m_b1 <= 1; m_b2 <= 1; m_bp <= 1;
        end else begin
            logic [3:0] p;
            p = m_pend;
            if (host_req && host_wr && host_addr == 3'd4) m_mode <= host_wdata[7:0];
            if (host_req && host_wr && host_addr == 3'd7) m_mask <= host_wdata[7:0];
            if (host_req && host_wr && host_addr == 3'd6) p = p & ~host_wdata[3:0];
            if (m_b2 && !m_bp) p[0] = 1'b1;
            if (!m_b2 && m_bp) p[1] = 1'b1;
            m_pend <= p;
            m_b1 <= nf_rb_n; m_b2 <= m_b1; m_bp <= m_b2;
        end
    end

    // Per-clock comparison of pins against the model, plus strobe widths.
    int we_run = 0, re_run = 0;
    always @(negedge clk) begin
        if (live) begin
            check({15'b0, nf_ce_n}, {15'b0, ~m_mode[4]}, "R2 ce_n");
            check({15'b0, nf_cle},  {15'b0, m_mode[0]},  "R2 cle");
            check({15'b0, nf_ale},  {15'b0, m_mode[1]},  "R2 ale");
            check({15'b0, nf_wp_n}, {15'b0, m_mode[7]},  "R2 wp_n");
            check({14'b0, ecc_sel}, {14'b0, m_mode[6:5]}, "R2 ecc_sel");
            check({15'b0, irq}, {15'b0, m_mask[7] & (|(m_pend & m_mask[3:0]))}, "R9 irq");
            check({15'b0, nf_we_n | nf_re_n}, 16'h1, "R6 strobe overlap");
            if (!nf_re_n) check({15'b0, nf_dq_oe}, 16'h0, "R6 drive on read");
            if (!nf_we_n) we_run++;
            else if (we_run > 0) begin check(16'(we_run), 16'(B_TPW), "R3 we width"); we_run = 0; end
            if (!nf_re_n) re_run++;
            else if (re_run > 0) begin check(16'(re_run), 16'(B_TPW), "R4 re width"); re_run = 0; end
        end
    end

    // Flash responder: supply read bytes, log written bytes with latch state.
    logic [7:0] rd_q[$];
    logic [9:0] wr_log[$];
    int re_cnt = 0;
    always @(negedge nf_re_n) begin
        if (rst_n) begin
            re_cnt++;
            nf_dq_in = (rd_q.size() > 0) ? rd_q.pop_front() : 8'hEE;
        end
    end
    always @(posedge nf_we_n) begin
        if (rst_n) begin
            wr_log.push_back({nf_cle, nf_ale, nf_dq_out});
            check({15'b0, nf_dq_oe}, 16'h1, "R3 dq_oe during write");
        end
    end

    task automatic access(input bit wr, input bit wide, input logic [2:0] a,
                          input logic [15:0] d, input int lat, output logic [15:0] rd);
        int k;
        @(negedge clk);
        host_req = 1; host_wr = wr; host_wide = wide; host_addr = a; host_wdata = d;
        @(posedge clk);
        @(negedge clk);
        host_req = 0;
        k = 0;
        while (!host_ack && k < 1000) begin @(negedge clk); k++; end
        rd = host_rdata;
        check(16'(k), 16'(lat), "R11 ack latency");
        @(negedge clk);
        check({15'b0, host_ack}, 16'h0, "R11 ack single");
    endtask

    task automatic wreg(input logic [2:0] a, input logic [7:0] d);
        logic [15:0] r;
        access(1, 0, a, {8'h00, d}, 0, r);
    endtask

    task automatic rreg(input logic [2:0] a, input logic [7:0] exp, input string tag);
        logic [15:0] r;
        access(0, 0, a, 16'h0, 0, r);
        check(r, {8'h00, exp}, tag);
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=done", checks);
        finish_run();
    end

    initial begin
        logic [15:0] r;
        int re0;
        wait_cyc(4);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check({15'b0, nf_ce_n}, 16'h1, "R1 ce_n");
        check({14'b0, nf_cle, nf_ale}, 16'h0, "R1 latches");
        check({14'b0, nf_we_n, nf_re_n}, 16'h3, "R1 strobes");
        check({13'b0, nf_dq_oe, irq, host_ack}, 16'h0, "R1 oe irq ack");
        check({15'b0, nf_wp_n}, 16'h0, "R1 wp_n");
        live = 1;
        rreg(3'd4, 8'h00, "R1 mode reads zero");

        // R2 + R3 command byte
        wreg(3'd4, 8'h95);
        rreg(3'd4, 8'h95, "R2 mode readback");
        access(1, 0, 3'd0, 16'hAB90, B_T, r);
        check(16'(wr_log.size()), 16'd1, "R3 one strobe for narrow write");
        if (wr_log.size() > 0) check({6'b0, wr_log.pop_front()}, {6'b0, 2'b10, 8'h90}, "R3 command byte");

        // R3 wide address write, low byte first
        wreg(3'd4, 8'h96);
        access(1, 1, 3'd0, 16'h3412, 2 * B_T, r);
        check(16'(wr_log.size()), 16'd2, "R3 two strobes for wide write");
        if (wr_log.size() > 1) begin
            check({6'b0, wr_log.pop_front()}, {6'b0, 2'b01, 8'h12}, "R3 first address byte");
            check({6'b0, wr_log.pop_front()}, {6'b0, 2'b01, 8'h34}, "R3 second address byte");
        end

        // R4 narrow read
        wreg(3'd4, 8'h94);
        rd_q.push_back(8'hA5);
        re0 = re_cnt;
        access(0, 0, 3'd0, 16'h0, B_T, r);
        check(r, 16'h00A5, "R4 narrow read");
        check(16'(re_cnt - re0), 16'd1, "R4 one read strobe");

        // R5 wide read
        rd_q.push_back(8'h11); rd_q.push_back(8'h22);
        re0 = re_cnt;
        access(0, 1, 3'd0, 16'h0, 2 * B_T, r);
        check(r, 16'h2211, "R5 wide read order");
        check(16'(re_cnt - re0), 16'd2, "R5 two read strobes");

        // R2 ecc select and standby
        wreg(3'd4, 8'hF4);
        check({14'b0, ecc_sel}, 16'h3, "R2 ecc_sel passthrough");
        wreg(3'd4, 8'h00);
        check({15'b0, nf_ce_n}, 16'h1, "R2 standby");

        // R7 + R8 busy edge
        @(negedge clk); nf_rb_n = 0;
        wait_cyc(4);
        rreg(3'd5, 8'h80, "R7 status busy");
        rreg(3'd6, 8'h02, "R8 busy edge flag");
        wreg(3'd7, 8'h81);
        check({15'b0, irq}, 16'h0, "R9 busy edge not enabled");
        @(negedge clk); nf_rb_n = 1;
        wait_cyc(4);
        check({15'b0, irq}, 16'h1, "R9 ready interrupt");
        rreg(3'd5, 8'h00, "R7 status ready");
        rreg(3'd6, 8'h03, "R8 both flags");
        wreg(3'd6, 8'h01);
        check({15'b0, irq}, 16'h0, "R9 irq after clearing ready flag");
        rreg(3'd6, 8'h02, "R8 partial clear");
        wreg(3'd6, 8'h0F);
        rreg(3'd6, 8'h00, "R8 clear all");

        // R9 master bit and full mask
        wreg(3'd7, 8'h01);
        @(negedge clk); nf_rb_n = 0;
        wait_cyc(4);
        @(negedge clk); nf_rb_n = 1;
        wait_cyc(4);
        check({15'b0, irq}, 16'h0, "R9 no irq without bit 7");
        wreg(3'd7, 8'h83);
        check({15'b0, irq}, 16'h1, "R9 irq with mask 0x83");
        wreg(3'd7, 8'h00);
        check({15'b0, irq}, 16'h0, "R9 mask all");

        // R10 unmapped offsets and status write
        wreg(3'd4, 8'h95);
        wreg(3'd1, 8'h55); wreg(3'd2, 8'h55); wreg(3'd3, 8'h55); wreg(3'd5, 8'h55);
        rreg(3'd4, 8'h95, "R10 mode untouched");
        rreg(3'd6, 8'h03, "R10 pending untouched");
        rreg(3'd7, 8'h00, "R10 mask untouched");
        rreg(3'd5, 8'h00, "R10 status untouched");
        rreg(3'd1, 8'h00, "R10 offset 1 reads zero");
        rreg(3'd3, 8'h00, "R10 offset 3 reads zero");
        check({15'b0, nf_cle}, 16'h1, "R10 pins untouched");

        wait_cyc(3);
        finish_run();
    end
endmodule